// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry colour lookup table, each entry made of an 8-bit red, an 8-bit green and an 8-bit blue value. Software loads it through a 16-byte register window on a 32-bit bus. One register picks the starting entry. Repeated writes to a second register then deliver the red, green and blue bytes of that entry in turn. After the blue byte the entry number steps forward by itself, so a whole table can be streamed with one index write followed by a run of data writes.

A pixel pipeline reads the table through a separate lookup port. The port is combinational: an entry number in gives 24-bit colour out in the same cycle. Each time a colour byte is stored, the block raises a one-cycle notice carrying the entry number, so a display controller downstream can schedule a redraw. Bus reads of the window return zero.

Top module: `clut_loader`

## Requirements
- R1: After reset every entry reads black (0x000000) on the lookup port, except entry 255, which reads white (0xFFFFFF); the entry pointer is 0 and the next data write goes to red.
- R2: An accepted write at byte offset 0x0 sets the entry pointer to write-data bits 31:24 and makes the next data write go to red, even when an entry was only partly written.
- R3: Accepted writes at byte offset 0x4 store write-data bits 31:24 into red, then green, then blue of the entry under the pointer; the lookup port packs an entry as {red[23:16], green[15:8], blue[7:0]}.
- R4: The data write that stores blue advances the pointer by one modulo 256 (255 is followed by 0) and returns the sequence to red.
- R5: A write is accepted only when bus_req, bus_we and all four byte enables (bus_be = 4'hF) are high; writes that are not accepted, and accepted writes to any offset other than 0x0 and 0x4, change no entry, pointer or sequence step.
- R6: bus_rdata is zero for every access, read or write, at every offset.
- R7: One cycle after each accepted data write, upd_valid is high for exactly one cycle and upd_idx holds the entry that was written; upd_valid is low in every other cycle.
- R8: lut_rgb reflects lut_idx combinationally, with no clock edge between a change of lut_idx and the new colour.
- R9: The sequence step never takes a value outside red, green and blue; an out-of-range step met on a data write would be returned to red with nothing stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data; colour or entry number in bits 31:24 |
| bus_rdata | output | 32 | Read data, always zero |
| lut_idx | input | 8 | Lookup entry number |
| lut_rgb | output | 24 | Colour of entry lut_idx, {red, green, blue} |
| upd_valid | output | 1 | One-cycle notice that a colour byte was stored |
| upd_idx | output | 8 | Entry that the notice refers to |

## Verification
On every cycle the assertions check that the step stays within red, green and blue, that an index write loads the pointer and rewinds the step, that a blue store advances the pointer with wrap, that the byte written lands in the chosen component, and that each notice follows a data write. What the assertions cannot show is the whole table: the reset contents of all 256 entries, that rejected and off-offset writes leave every entry untouched, and that a long mixed stream of accesses ends in the same table as the bench's own model; those come from the bench's scenarios and full-table scans.

// File: rtl/clut_pkg.sv
package clut_pkg;
    localparam int unsigned ENTRIES = 256;
    localparam int unsigned IDX_W   = $clog2(ENTRIES);
    localparam int unsigned COMP_W  = 8;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned BE_W    = DATA_W / 8;

    localparam logic [ADDR_W-1:0] OFF_POINTER = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_COLOUR  = 4'h4;

    typedef enum logic [1:0] {
        STEP_RED = 2'd0,
        STEP_GRN = 2'd1,
        STEP_BLU = 2'd2
    } step_e;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
        logic [COMP_W-1:0] blu;
    } colour_t;
endpackage

// File: rtl/clut_decode.sv
module clut_decode
    import clut_pkg::*;
(
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ptr_wr_o,
    output logic              col_wr_o,
    output logic [COMP_W-1:0] byte_o
);
    logic accept;

    always_comb begin
        accept   = req_i && we_i && (be_i == {BE_W{1'b1}});
        ptr_wr_o = accept && (addr_i == OFF_POINTER);
        col_wr_o = accept && (addr_i == OFF_COLOUR);
        byte_o   = wdata_i[DATA_W-1 -: COMP_W];
    end
endmodule

// File: rtl/clut_sequencer.sv
module clut_sequencer
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr_i,
    input  logic              col_wr_i,
    input  logic [COMP_W-1:0] byte_i,
    output logic              store_we_o,
    output step_e             store_sel_o,
    output logic [IDX_W-1:0]  store_idx_o,
    output logic              upd_valid_o,
    output logic [IDX_W-1:0]  upd_idx_o
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
        step_e            step;
        logic             upd;
        logic [IDX_W-1:0] upd_idx;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       hit_d;

    always_comb begin
        st_d        = st_q;
        st_d.upd    = 1'b0;
        hit_d       = 1'b0;
        if (ptr_wr_i) begin
            st_d.ptr  = IDX_W'(byte_i);
            st_d.step = STEP_RED;
        end else if (col_wr_i) begin
            case (st_q.step)
                STEP_RED: begin
                    hit_d     = 1'b1;
                    st_d.step = STEP_GRN;
                end
                STEP_GRN: begin
                    hit_d     = 1'b1;
                    st_d.step = STEP_BLU;
                end
                STEP_BLU: begin
                    hit_d     = 1'b1;
                    st_d.step = STEP_RED;
                    st_d.ptr  = st_q.ptr + 1'b1;
                end
                default: begin
                    st_d.step = STEP_RED;
                end
            endcase
            if (hit_d) begin
                st_d.upd     = 1'b1;
                st_d.upd_idx = st_q.ptr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ptr: '0, step: STEP_RED, upd: 1'b0, upd_idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign store_we_o  = hit_d;
    assign store_sel_o = st_q.step;
    assign store_idx_o = st_q.ptr;
    assign upd_valid_o = st_q.upd;
    assign upd_idx_o   = st_q.upd_idx;

    AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.step != 2'd3); // R9
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr_i |=> (st_q.ptr == $past(byte_i)) && (st_q.step == STEP_RED)); // R2
    AST_BLUE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr_i && !ptr_wr_i && st_q.step == STEP_BLU)
        |=> (st_q.ptr == $past(st_q.ptr) + 1'b1) && (st_q.step == STEP_RED)); // R4
    AST_NOTICE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o |-> $past(col_wr_i) && !$past(ptr_wr_i)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_wr_i && !col_wr_i) |=> $stable(st_q.ptr) && $stable(st_q.step)); // R5
endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  step_e             sel_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [COMP_W-1:0] byte_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [3*COMP_W-1:0] rgb_o
);
    colour_t mem_d [ENTRIES];
    colour_t mem_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            case (sel_i)
                STEP_RED: mem_d[widx_i].red = byte_i;
                STEP_GRN: mem_d[widx_i].grn = byte_i;
                STEP_BLU: mem_d[widx_i].blu = byte_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= (i == ENTRIES - 1) ? '1 : '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rgb_o = mem_q[ridx_i];

    AST_RED_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == STEP_RED) |=> mem_q[$past(widx_i)].red == $past(byte_i)); // R3
    AST_GRN_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == STEP_GRN) |=> mem_q[$past(widx_i)].grn == $past(byte_i)); // R3
    AST_BLU_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == STEP_BLU) |=> mem_q[$past(widx_i)].blu == $past(byte_i)); // R3
endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  lut_idx,
    output logic [3*COMP_W-1:0] lut_rgb,
    output logic              upd_valid,
    output logic [IDX_W-1:0]  upd_idx
);
    logic              ptr_wr, col_wr, store_we;
    logic [COMP_W-1:0] wbyte;
    step_e             store_sel;
    logic [IDX_W-1:0]  store_idx;

    clut_decode u_decode (
        .req_i    (bus_req),
        .we_i     (bus_we),
        .addr_i   (bus_addr),
        .be_i     (bus_be),
        .wdata_i  (bus_wdata),
        .ptr_wr_o (ptr_wr),
        .col_wr_o (col_wr),
        .byte_o   (wbyte)
    );

    clut_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr_wr_i    (ptr_wr),
        .col_wr_i    (col_wr),
        .byte_i      (wbyte),
        .store_we_o  (store_we),
        .store_sel_o (store_sel),
        .store_idx_o (store_idx),
        .upd_valid_o (upd_valid),
        .upd_idx_o   (upd_idx)
    );

    clut_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (store_we),
        .sel_i  (store_sel),
        .widx_i (store_idx),
        .byte_i (wbyte),
        .ridx_i (lut_idx),
        .rgb_o  (lut_rgb)
    );

    assign bus_rdata = '0;

    AST_NOTICE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !(bus_req && bus_we && bus_be == 4'hF && bus_addr == OFF_COLOUR))
        |=> !upd_valid); // R7
    AST_NOTICE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(store_idx) == upd_idx); // R7
endmodule

// File: tb/clut_loader_bench.sv
module clut_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0, bus_be = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [7:0]  lut_idx = '0, upd_idx;
    logic [23:0] lut_rgb;
    logic        upd_valid;

    int vectors = 0, errors = 0;
    int m_r[256], m_g[256], m_b[256];
    int m_ptr = 0, m_step = 0;
    bit exp_upd = 0;
    int exp_uidx = 0;
    bit done = 0;

    always #2 clk = ~clk;

    clut_loader u_clut_loader (.*);

    function automatic int exp_rgb(int i);
        return (m_r[i] << 16) | (m_g[i] << 8) | m_b[i];
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            m_r[i] = (i == 255) ? 255 : 0;
            m_g[i] = m_r[i];
            m_b[i] = m_r[i];
        end
        m_ptr = 0; m_step = 0; exp_upd = 0;
    endtask

    // behavioural reference for one clocked access
    task automatic model_apply(bit req, bit we, int addr, int be, int data);
        int top8 = (data >> 24) & 255;
        exp_upd = 0;
        if (req && we && be == 15) begin
            if (addr == 0) begin
                m_ptr = top8; m_step = 0;
            end else if (addr == 4) begin
                exp_upd = 1; exp_uidx = m_ptr;
                if (m_step == 0) m_r[m_ptr] = top8;
                else if (m_step == 1) m_g[m_ptr] = top8;
                else m_b[m_ptr] = top8;
                m_step++;
                if (m_step == 3) begin
                    m_step = 0; m_ptr = (m_ptr + 1) % 256;
                end
            end
        end
    endtask

    task automatic access(bit req, bit we, int addr, int be, int data, int look, string req_tag);
        @(negedge clk);
        bus_req = req; bus_we = we; bus_addr = addr[3:0];
        bus_be = be[3:0]; bus_wdata = data; lut_idx = look[7:0];
        #0.5;
        check(bus_rdata == 0, "R6", bus_rdata, 0);
        @(posedge clk);
        model_apply(req, we, addr, be, data);
        @(negedge clk);
        check(upd_valid == exp_upd, {req_tag, "/R7 valid"}, upd_valid, exp_upd);
        if (exp_upd) check(upd_idx == exp_uidx[7:0], "R7 idx", upd_idx, exp_uidx);
        check(lut_rgb == exp_rgb(look), {req_tag, " lookup"}, lut_rgb, exp_rgb(look));
        bus_req = 0; bus_we = 0;
    endtask

    task automatic scan(string tag);
        for (int i = 0; i < 256; i++) begin
            lut_idx = i[7:0];
            #0.1;
            check(lut_rgb == exp_rgb(i), tag, lut_rgb, exp_rgb(i));
        end
    endtask

    initial begin
        int look;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(upd_valid == 0, "R1 notice", upd_valid, 0);
        scan("R1 reset table");

        // R2 / R3: entry 5 loaded red, green, blue
        access(1, 1, 0, 15, 32'h05_00_00_00, 5, "R2");
        access(1, 1, 4, 15, 32'h11_ff_ff_ff, 5, "R3 red");
        access(1, 1, 4, 15, 32'h22_00_00_00, 5, "R3 grn");
        access(1, 1, 4, 15, 32'h33_00_00_00, 5, "R3 blu");
        // R4: pointer advanced to 6
        access(1, 1, 4, 15, 32'h44_00_00_00, 6, "R4 advance");
        // R4: wrap at 255
        access(1, 1, 0, 15, 32'hff_00_00_00, 255, "R2");
        access(1, 1, 4, 15, 32'h01_00_00_00, 255, "R4");
        access(1, 1, 4, 15, 32'h02_00_00_00, 255, "R4");
        access(1, 1, 4, 15, 32'h03_00_00_00, 255, "R4");
        access(1, 1, 4, 15, 32'h77_00_00_00, 0, "R4 wrap");
        // R2: index write after partial entry rewinds to red
        access(1, 1, 0, 15, 32'h0a_00_00_00, 10, "R2");
        access(1, 1, 4, 15, 32'h55_00_00_00, 10, "R2");
        access(1, 1, 0, 15, 32'h0b_00_00_00, 11, "R2");
        access(1, 1, 4, 15, 32'h66_00_00_00, 11, "R2 rewind red");
        // R5: rejected and off-offset writes, R6 reads
        access(1, 1, 8,  15, 32'h99_00_00_00, 11, "R5 off8");
        access(1, 1, 12, 15, 32'h99_00_00_00, 11, "R5 offC");
        access(1, 1, 4,  7,  32'h99_00_00_00, 11, "R5 partial be");
        access(0, 1, 4,  15, 32'h99_00_00_00, 11, "R5 no req");
        access(1, 0, 4,  15, 32'h99_00_00_00, 11, "R6 read");
        access(1, 0, 0,  15, 32'h99_00_00_00, 11, "R6 read");
        access(1, 1, 4, 15, 32'h88_00_00_00, 11, "R5 step kept");
        scan("R5 table");
        // R8: lookup changes with no clock edge
        @(negedge clk);
        lut_idx = 5; #0.2;
        check(lut_rgb == exp_rgb(5), "R8", lut_rgb, exp_rgb(5));
        lut_idx = 10; #0.2;
        check(lut_rgb == exp_rgb(10), "R8", lut_rgb, exp_rgb(10));
        // mixed stream
        for (int n = 0; n < 3000; n++) begin
            int sel = $urandom_range(0, 9);
            int addr = (sel == 0) ? 0 : (sel < 8) ? 4 : $urandom_range(0, 15);
            int be = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 15) : 15;
            look = $urandom_range(0, 255);
            access($urandom_range(0, 9) != 0, $urandom_range(0, 7) != 0, addr, be,
                   $urandom, look, "R3 stream");
        end
        scan("R3 final table");
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++; errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule